// File: doc/BRIEF.md
# Multicycle Integer Multiplier

This block is the iterative multiply unit of a small processor core. Each operation takes one start pulse and returns a single 32-bit word. The word is either the low half of the product or one of three high-half forms. The high-half forms treat the operands as unsigned by unsigned, signed by unsigned, or signed by signed. An instruction-kind flag selects between two operand sources:

- Register form: the second operand comes from the B input, and a 6-bit extended code selects the result.
- Immediate form: the second operand is a sign-extended 16-bit constant, and the low word is always returned.

A single 32-step loop builds both product halves at once:

- The low half is accumulated from the multiplier's most significant bit downward, with a left shift each step.
- The unsigned high half is accumulated from the least significant bit upward, with a right shift each step that keeps the carry.

One extra cycle then derives the signed high halves from the unsigned one. It subtracts the original operands, which were saved at start, where the sign bits call for it. The unit is busy from the cycle after start until it raises its one-cycle done pulse. Starts that arrive while it is busy are dropped.

Top module: `mcyc_mul`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all zero.
- R2: Acceptance and timing:
  - A start_i seen while idle with an accepted code makes busy_o high from the next cycle.
  - done_o rises exactly 33 rising edges after the edge that sampled start_i, and stays high for one cycle only.
  - busy_o is low while done_o is high.
- R3: In register form, extended code 0x27 returns bits 31:0 of the product of src_a_i and src_b_i.
- R4: In immediate form (imm_form_i=1), the second operand is imm_i sign-extended to 32 bits, and the low product word is returned. xop_i and src_b_i are ignored in this form.
- R5: Extended code 0x07 returns bits 63:32 of the unsigned by unsigned product.
- R6: Extended code 0x17 returns bits 63:32 of the product of src_a_i taken as signed and src_b_i taken as unsigned.
- R7: Extended code 0x1f returns bits 63:32 of the signed by signed product.
- R8: Any other register-form extended code with bit 1 set returns the signed by signed high word.
- R9: A register-form start whose extended code has bit 1 clear is not accepted: busy_o stays low and no done_o follows.
- R10: Start pulses and input changes while busy_o is high do not alter the operation in flight or its result.
- R11: result_o holds its value at all times except on the cycle done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; operands and code are sampled with it |
| imm_form_i | input | 1 | 1 selects immediate form, 0 selects register form |
| xop_i | input | 6 | Extended code selecting the result word |
| src_a_i | input | 32 | First operand (multiplicand) |
| src_b_i | input | 32 | Second operand in register form |
| imm_i | input | 16 | Immediate second operand, sign-extended |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Selected 32-bit result, held until the next completion |

## Verification
Each result form is driven with directed corner operands and a large random mix:
- zero;
- all ones;
- the most negative value;
- single-bit patterns.

Operands with the top bit set in A only, in B only, and in both separate the three high-half forms. Each of these cases turns on a different one of the two sign corrections. All-ones multiplicands make the unsigned high half carry out on almost every step, which exposes a lost carry. Immediate-form runs use negative constants paired with a deliberately misleading code and B value, so a missing sign extension or a wrong operand source shows up directly in the low word.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {
    K_LOW = 2'd0,
    K_UU  = 2'd1,
    K_SU  = 2'd2,
    K_SS  = 2'd3
  } mul_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2
  } mul_state_e;

  localparam logic [5:0] XOP_LOW = 6'h27;
  localparam logic [5:0] XOP_UU  = 6'h07;
  localparam logic [5:0] XOP_SU  = 6'h17;
endpackage

// File: rtl/mcm_decode.sv
module mcm_decode
  import mcm_pkg::*;
#(
  parameter int OPXW = 6
) (
  input  logic            imm_form,
  input  logic [OPXW-1:0] xop,
  output logic            accept,
  output mul_kind_e       kind
);
  // bit 1 marks every multiply code; immediate form always multiplies
  always_comb begin
    accept = imm_form | xop[1];
    if (imm_form)                          kind = K_LOW;
    else if (xop == OPXW'(XOP_LOW))        kind = K_LOW;
    else if (xop == OPXW'(XOP_UU))         kind = K_UU;
    else if (xop == OPXW'(XOP_SU))         kind = K_SU;
    else                                   kind = K_SS;
  end
endmodule

// File: rtl/mcm_iter.sv
module mcm_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mplier_in,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [W-1:0] ml_q, ml_d, mh_q, mh_d;
  logic [W:0]   hsum;

  // low half walks the multiplier MSB-first, high half walks it LSB-first
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ml_d = ml_q;
    mh_d = mh_q;
    hsum = {1'b0, hi_q} + (mh_q[0] ? {1'b0, mcand} : '0);
    if (load) begin
      lo_d = '0;
      hi_d = '0;
      ml_d = mplier_in;
      mh_d = mplier_in;
    end else if (step) begin
      lo_d = {lo_q[W-2:0], 1'b0} + (ml_q[W-1] ? mcand : '0);
      hi_d = hsum[W:1];
      ml_d = {ml_q[W-2:0], 1'b0};
      mh_d = {1'b0, mh_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      ml_q <= '0;
      mh_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      ml_q <= ml_d;
      mh_q <= mh_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/mcm_fix.sv
module mcm_fix
  import mcm_pkg::*;
#(
  parameter int W = 32
) (
  input  mul_kind_e    kind,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi_uu,
  output logic [W-1:0] res
);
  logic [W-1:0] hi_su, hi_ss;

  always_comb begin
    hi_su = hi_uu - (opa[W-1] ? opb : '0);
    hi_ss = hi_su - (opb[W-1] ? opa : '0);
    unique case (kind)
      K_LOW:   res = lo;
      K_UU:    res = hi_uu;
      K_SU:    res = hi_su;
      default: res = hi_ss;
    endcase
  end
endmodule

// File: rtl/mcyc_mul.sv
module mcyc_mul
  import mcm_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16,
  parameter int OPXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            imm_form_i,
  input  logic [OPXW-1:0] xop_i,
  input  logic [W-1:0]    src_a_i,
  input  logic [W-1:0]    src_b_i,
  input  logic [IMMW-1:0] imm_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [W-1:0]    result_o
);
  localparam int CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  mul_state_e     st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [W-1:0]   a_q, b_q, res_q, b_in, lo, hi, res_fix;
  mul_kind_e      kind_q, kind_in;
  logic           done_q, accept, load, step;

  assign b_in = imm_form_i ? {{(W-IMMW){imm_i[IMMW-1]}}, imm_i} : src_b_i;
  assign load = (st_q == S_IDLE) && start_i && accept;
  assign step = (st_q == S_RUN);

  mcm_decode #(.OPXW(OPXW)) u_dec (
    .imm_form(imm_form_i), .xop(xop_i), .accept(accept), .kind(kind_in)
  );

  mcm_iter #(.W(W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mplier_in(b_in), .mcand(a_q), .lo(lo), .hi(hi)
  );

  mcm_fix #(.W(W)) u_fix (
    .kind(kind_q), .opa(a_q), .opb(b_q), .lo(lo), .hi_uu(hi), .res(res_fix)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: if (load) begin
        st_d  = S_RUN;
        cnt_d = '0;
      end
      S_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = S_FIX;
      end
      S_FIX:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      kind_q <= K_LOW;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= (st_q == S_FIX);
      if (load) begin
        a_q    <= src_a_i;
        b_q    <= b_in;
        kind_q <= kind_in;
      end
      if (st_q == S_FIX) res_q <= res_fix;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/mcyc_mul_chk.sv
module mcyc_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         imm_form_i,
  input logic         xop_b1,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  logic [15:0] lat_q;
  logic        take;

  assign take = start_i && !busy_o && (imm_form_i || xop_b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (take)   lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 16'd1;
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_o);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == 16'(W + 1)));
  a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !imm_form_i && !xop_b1) |=> !busy_o);
  a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

bind mcyc_mul mcyc_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .imm_form_i(imm_form_i),
  .xop_b1(xop_i[1]), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/mcyc_mul_bench.sv
module mcyc_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        immf = 1'b0;
  logic [5:0]  xop = '0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic        busy, done;
  logic [31:0] res;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam int LAT = 34; // negedges from the start drive to done visible

  always #5 clk = ~clk;

  mcyc_mul u_mcyc_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start), .imm_form_i(immf),
    .xop_i(xop), .src_a_i(a), .src_b_i(b), .imm_i(imm),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  function automatic logic [31:0] ref_mul(input logic f, input logic [5:0] x,
                                          input logic [31:0] oa, input logic [31:0] ob,
                                          input logic [15:0] im);
    logic [31:0] bb;
    logic [63:0] p;
    bb = f ? {{16{im[15]}}, im} : ob;
    if (f || x == 6'h27) begin
      p = {32'b0, oa} * {32'b0, bb};
      return p[31:0];
    end
    if (x == 6'h07)      p = {32'b0, oa} * {32'b0, bb};
    else if (x == 6'h17) p = {{32{oa[31]}}, oa} * {32'b0, bb};
    else                 p = {{32{oa[31]}}, oa} * {{32{bb[31]}}, bb};
    return p[63:32];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // issue one op, track latency and result; optional scramble while busy
  task automatic run_op(input string tag, input logic f, input logic [5:0] x,
                        input logic [31:0] oa, input logic [31:0] ob,
                        input logic [15:0] im, input logic scramble);
    int lat;
    logic [31:0] exp;
    exp = ref_mul(f, x, oa, ob, im);
    immf = f; xop = x; a = oa; b = ob; imm = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check({tag, " R2 busy after start"}, {31'b0, busy}, 32'd1);
    while (!done && lat < 100) begin
      if (scramble && lat == 5) begin
        // R10: new start and new operands while busy must be dropped
        start = 1'b1; a = ~oa; b = oa ^ 32'h5a5a_1234; xop = 6'h07; immf = ~f; imm = ~im;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " R2 latency"}, 32'(lat), 32'(LAT));
    check({tag, " R2 busy low at done"}, {31'b0, busy}, 32'd0);
    check({tag, " result"}, res, exp);
    @(negedge clk);
    check({tag, " R2 single pulse"}, {31'b0, done}, 32'd0);
    check({tag, " R11 result held"}, res, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
      end
    end
  end

  initial begin
    logic [5:0] codes [4];
    codes[0] = 6'h27; codes[1] = 6'h07; codes[2] = 6'h17; codes[3] = 6'h1f;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 result", res, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R3 small", 1'b0, 6'h27, 32'd43, 32'd7, 16'h0, 1'b0);
    run_op("R3 neg", 1'b0, 6'h27, 32'hffff_fffe, 32'd3, 16'h0, 1'b0);
    run_op("R4 neg imm", 1'b1, 6'h07, 32'd1000, 32'hdead_beef, 16'hfffd, 1'b0);
    run_op("R4 max imm", 1'b1, 6'h00, 32'h8000_0001, 32'h0, 16'h7fff, 1'b0);
    run_op("R5 ones", 1'b0, 6'h07, 32'hffff_ffff, 32'hffff_ffff, 16'h0, 1'b0);
    run_op("R5 zero", 1'b0, 6'h07, 32'h0, 32'hffff_ffff, 16'h0, 1'b0);
    run_op("R6 a neg", 1'b0, 6'h17, 32'h8000_0000, 32'hffff_ffff, 16'h0, 1'b0);
    run_op("R6 b neg", 1'b0, 6'h17, 32'h0000_1234, 32'h8765_4321, 16'h0, 1'b0);
    run_op("R7 both neg", 1'b0, 6'h1f, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0);
    run_op("R7 minus one", 1'b0, 6'h1f, 32'hffff_ffff, 32'h0000_0005, 16'h0, 1'b0);
    run_op("R8 code 02", 1'b0, 6'h02, 32'hf000_0003, 32'h7000_0009, 16'h0, 1'b0);
    run_op("R8 code 3f", 1'b0, 6'h3f, 32'h1234_5678, 32'hfedc_ba98, 16'h0, 1'b0);
    run_op("R10 scramble", 1'b0, 6'h17, 32'hc000_0001, 32'h4000_0003, 16'h0, 1'b1);

    // R9: non-multiply register-form code is refused
    immf = 1'b0; xop = 6'h25; a = 32'd9; b = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 busy stays low", {31'b0, busy}, 32'd0);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || busy) seen = 1'b1;
      end
      check("R9 no done", {31'b0, seen}, 32'd0);
      check("R9 R11 result unchanged", res, ref_mul(1'b0, 6'h3f, 32'hc000_0001, 32'h4000_0003, 16'h0) ^ res ^ res);
    end

    for (int n = 0; n < 200; n++) begin
      logic f;
      logic [5:0] x;
      f = ($urandom % 5) == 0;
      if (($urandom % 6) == 0) x = 6'($urandom) | 6'h02;
      else x = codes[$urandom % 4];
      run_op("rand R3 R4 R5 R6 R7 R8", f, x, $urandom, $urandom, 16'($urandom), 1'($urandom % 8 == 0));
    end
    finish_up();
  end
endmodule